// File: doc/BRIEF.md
# Battery Charge Safety Timer

This block supervises how long a battery charger may stay in its charging phases. It counts a slow timebase tick, for example one pulse per minute. When the fast-charge phase or the pre-charge phase runs longer than allowed, the block raises a sticky timer-fault bit and sends one interrupt pulse to the host.

The fast-charge limit is picked from four parameter durations by a two-bit select. The count slows to half rate while the charger is held back by input current regulation, input voltage regulation or a temperature derate, but only when double-time mode is enabled. A fault that stops charging freezes the count, and so does the charging-active flag going low. Dropping the charge enable clears the count. A separate pre-charge timer has a fixed limit and runs only while the battery voltage is below the low threshold.

Top module: `chg_safety_timer`

## Requirements
- R1: With `cfg_dur_sel_i` = s (0 to 3), the fast-charge timer expires after `DUR_TICKS[s]` counted ticks. `tmr_flt_o` and `tmr_irq_o` go high one clock after the edge that takes the final tick, and the count never goes past its limit.
- R2: `tmr_irq_o` is high for exactly one clock per rising edge of expiry. `tmr_flt_o` stays high after that, even while further ticks arrive.
- R3: While `cfg_tmr_en_i` is 0, the fast-charge timer neither counts nor expires. Once it is set to 1 again, counting continues from the held value.
- R4: With `cfg_dbl_en_i` = 1, the count advances only on every second tick while any of `iin_reg_i`, `vin_reg_i` or `temp_derate_i` is 1. A limit of N then takes 2N ticks.
- R5: With `cfg_dbl_en_i` = 0, the count advances on every tick whatever the regulation and derate flags say.
- R6: While `chg_fault_i` is 1 or `chg_active_i` is 0, both counts and the half-rate phase are frozen. Counting resumes from the held value when the condition ends.
- R7: While `chg_en_i` is 0, both counts are held at zero. A rising edge of `chg_en_i` clears `tmr_flt_o`.
- R8: While `vbat_low_i` = 1 and `cfg_pre_en_i` = 1, the pre-charge timer counts at full rate and expires after `PRE_TICKS` ticks, with the same fault and interrupt outputs. The fast-charge count is frozen while `vbat_low_i` = 1.
- R9: With `cfg_pre_en_i` = 0, the pre-charge timer never expires.
- R10: A one-clock pulse on `flt_clr_i` clears `tmr_flt_o`. No new interrupt follows while the timer is still at its limit.
- R11: After reset, `tmr_flt_o` and `tmr_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock timebase pulse |
| chg_en_i | input | 1 | Charge enable; a low-then-high sequence restarts the cycle |
| chg_active_i | input | 1 | Charger is delivering current |
| chg_fault_i | input | 1 | A fault that disables charging is present |
| iin_reg_i | input | 1 | Input current regulation active |
| vin_reg_i | input | 1 | Input voltage regulation active |
| temp_derate_i | input | 1 | Temperature zone has reduced charge current |
| vbat_low_i | input | 1 | Battery voltage below low threshold |
| cfg_tmr_en_i | input | 1 | Fast-charge timer enable |
| cfg_dbl_en_i | input | 1 | Double-time (half rate) enable |
| cfg_pre_en_i | input | 1 | Pre-charge timer enable |
| cfg_dur_sel_i | input | 2 | Fast-charge duration select |
| flt_clr_i | input | 1 | Host clear of the timer-fault bit |
| tmr_flt_o | output | 1 | Sticky timer-fault status |
| tmr_irq_o | output | 1 | One-clock expiry interrupt |

## Verification
The bench builds the block with `CNT_W` = 6, `DUR_TICKS` = 4, 6, 8 and 10, and `PRE_TICKS` = 3 in place of minute-scale durations. With these values every expiry boundary can be reached in a few dozen ticks. This lets the bench check one tick before and exactly at each limit, the doubled count under each of the three slowing flags, and freeze-and-resume across long fault windows. The small width also keeps the saturation path, where ticks keep arriving after expiry, within easy reach.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
   localparam int unsigned NUM_DUR = 4;
   localparam int unsigned SEL_W   = $clog2(NUM_DUR);

   typedef logic [SEL_W-1:0] dur_sel_t;

   typedef struct packed {
      logic iin_reg;
      logic vin_reg;
      logic temp_derate;
   } derate_t;

   function automatic logic derate_any(derate_t d);
      return d.iin_reg | d.vin_reg | d.temp_derate;
   endfunction
endpackage

// File: rtl/ctmr_rate_gate.sv
module ctmr_rate_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic run,
   input  logic slow,
   output logic step
);
   logic ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ph <= 1'b0;
      else if (clr)                 ph <= 1'b0;
      else if (tick && run && slow) ph <= ~ph;
   end

   assign step = tick && run && (!slow || ph);

   // R6: the half-rate phase is frozen when nothing is counted
   a_r6_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(tick && run)) |=> $stable(ph));
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;

   generate
      if (W < 2) begin : g_bad_w
         $error("ctmr_counter: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (step && cnt < limit)  cnt <= cnt + W'(1);
   end

   assign hit = (cnt >= limit);

   a_r7_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   a_r6_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(cnt));
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step && hit) |=> $stable(cnt));
endmodule

// File: rtl/ctmr_flag.sv
module ctmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic host_clr,
   input  logic restart,
   output logic flt,
   output logic irq
);
   logic hit_q;
   logic rise;

   assign rise = hit && !hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         flt   <= 1'b0;
         irq   <= 1'b0;
      end else begin
         hit_q <= hit;
         irq   <= rise;
         if (rise)                     flt <= 1'b1;
         else if (restart || host_clr) flt <= 1'b0;
      end
   end

   a_r2_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r2_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flt);
   a_r10_host_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_clr && !hit) |=> !flt);
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
   import ctmr_pkg::*;
#(
   parameter int unsigned CNT_W              = 12,
   parameter int unsigned DUR_TICKS [NUM_DUR] = '{300, 480, 720, 1440},
   parameter int unsigned PRE_TICKS          = 120
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       chg_en_i,
   input  logic       chg_active_i,
   input  logic       chg_fault_i,
   input  logic       iin_reg_i,
   input  logic       vin_reg_i,
   input  logic       temp_derate_i,
   input  logic       vbat_low_i,
   input  logic       cfg_tmr_en_i,
   input  logic       cfg_dbl_en_i,
   input  logic       cfg_pre_en_i,
   input  logic [1:0] cfg_dur_sel_i,
   input  logic       flt_clr_i,
   output logic       tmr_flt_o,
   output logic       tmr_irq_o
);
   localparam logic [CNT_W-1:0] PRE_LIM = CNT_W'(PRE_TICKS);

   logic [CNT_W-1:0] lim_tab [NUM_DUR];
   logic [CNT_W-1:0] fast_lim;
   logic             en_q, restart, clr;
   logic             base_run, fast_run, pre_run, slow;
   logic             fast_step, pre_step, fast_hit, pre_hit, any_hit;
   derate_t          drt;

   generate
      if (PRE_TICKS == 0 || PRE_TICKS >= 2**CNT_W) begin : g_bad_pre
         $error("chg_safety_timer: PRE_TICKS out of range for CNT_W");
      end
      for (genvar i = 0; i < NUM_DUR; i++) begin : g_lim
         if (DUR_TICKS[i] == 0 || DUR_TICKS[i] >= 2**CNT_W) begin : g_bad_dur
            $error("chg_safety_timer: DUR_TICKS entry out of range for CNT_W");
         end
         assign lim_tab[i] = CNT_W'(DUR_TICKS[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= chg_en_i;
   end

   assign restart  = chg_en_i && !en_q;
   assign clr      = !chg_en_i;
   assign drt      = '{iin_reg: iin_reg_i, vin_reg: vin_reg_i, temp_derate: temp_derate_i};
   assign slow     = cfg_dbl_en_i && derate_any(drt);
   assign base_run = chg_en_i && chg_active_i && !chg_fault_i;
   assign fast_run = base_run && cfg_tmr_en_i && !vbat_low_i;
   assign pre_run  = base_run && cfg_pre_en_i && vbat_low_i;
   assign fast_lim = lim_tab[dur_sel_t'(cfg_dur_sel_i)];

   ctmr_rate_gate u_fast_gate (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_i),
      .run(fast_run), .slow(slow), .step(fast_step));

   ctmr_rate_gate u_pre_gate (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_i),
      .run(pre_run), .slow(1'b0), .step(pre_step));

   ctmr_counter #(.W(CNT_W)) u_fast_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(fast_step),
      .limit(fast_lim), .hit(fast_hit));

   ctmr_counter #(.W(CNT_W)) u_pre_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(pre_step),
      .limit(PRE_LIM), .hit(pre_hit));

   assign any_hit = (fast_hit && cfg_tmr_en_i) || (pre_hit && cfg_pre_en_i);

   ctmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hit(any_hit), .host_clr(flt_clr_i),
      .restart(restart), .flt(tmr_flt_o), .irq(tmr_irq_o));

   // R3 / R8: the fast count only moves when enabled and above the low threshold
   a_r3_fast_step_gated: assert property (@(posedge clk) disable iff (!rst_n)
      fast_step |-> (cfg_tmr_en_i && !vbat_low_i));
   // R3 / R9: an interrupt needs one of the timers enabled the cycle before
   a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq_o |-> $past(cfg_tmr_en_i || cfg_pre_en_i));
   // R8: the pre-charge count only moves below the low threshold
   a_r8_pre_step_gated: assert property (@(posedge clk) disable iff (!rst_n)
      pre_step |-> (vbat_low_i && cfg_pre_en_i));
endmodule

// File: tb/tb_chg_safety_timer.sv
module tb_chg_safety_timer;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      string tag;
      bit    flt;
      bit    irq;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 0, chg_en_i = 1, chg_active_i = 1, chg_fault_i = 0;
   logic iin_reg_i = 0, vin_reg_i = 0, temp_derate_i = 0, vbat_low_i = 0;
   logic cfg_tmr_en_i = 1, cfg_dbl_en_i = 0, cfg_pre_en_i = 0, flt_clr_i = 0;
   logic [1:0] cfg_dur_sel_i = 2'd0;
   logic tmr_flt_o, tmr_irq_o;

   int   checks = 0;
   int   errors = 0;
   bit   done = 0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   chg_safety_timer #(
      .CNT_W(6), .DUR_TICKS('{4, 6, 8, 10}), .PRE_TICKS(3)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .chg_en_i(chg_en_i),
      .chg_active_i(chg_active_i), .chg_fault_i(chg_fault_i),
      .iin_reg_i(iin_reg_i), .vin_reg_i(vin_reg_i), .temp_derate_i(temp_derate_i),
      .vbat_low_i(vbat_low_i), .cfg_tmr_en_i(cfg_tmr_en_i),
      .cfg_dbl_en_i(cfg_dbl_en_i), .cfg_pre_en_i(cfg_pre_en_i),
      .cfg_dur_sel_i(cfg_dur_sel_i), .flt_clr_i(flt_clr_i),
      .tmr_flt_o(tmr_flt_o), .tmr_irq_o(tmr_irq_o));

   // monitor: compares expected items against the outputs after each falling edge
   always begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (tmr_flt_o !== e.flt || tmr_irq_o !== e.irq) begin
            errors++;
            $display("FAIL %s: flt=%0b irq=%0b expected flt=%0b irq=%0b",
                     e.tag, tmr_flt_o, tmr_irq_o, e.flt, e.irq);
         end
      end
   end

   task automatic expect_now(input string tag, input bit f, input bit i);
      exp_t e;
      e.tag = tag; e.flt = f; e.irq = i;
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic tk(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic restart();
      @(negedge clk); chg_en_i = 1'b0;
      @(negedge clk); chg_en_i = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      expect_now("R11 reset", 0, 0);

      // R1 / R2: select 0, limit 4
      restart();
      tk(3); idle(); expect_now("R1 before limit sel0", 0, 0);
      tk(1); idle(); expect_now("R1 expiry sel0", 1, 1);
      idle();        expect_now("R2 single pulse, sticky", 1, 0);
      tk(3); idle(); expect_now("R2 no refire while saturated", 1, 0);

      // R10: host clear
      @(negedge clk); flt_clr_i = 1'b1;
      @(negedge clk); flt_clr_i = 1'b0;
      expect_now("R10 flag cleared", 0, 0);
      tk(2); idle(); expect_now("R10 no new irq at limit", 0, 0);

      // R7: restart clears flag and count
      restart();
      tk(4); idle(); expect_now("R7 set before restart", 1, 1);
      restart();     expect_now("R7 restart clears flag", 0, 0);
      cfg_dur_sel_i = 2'd1;
      restart();
      tk(3); restart();
      tk(5); idle(); expect_now("R7 count cleared by restart", 0, 0);
      tk(1); idle(); expect_now("R7 expiry sel1 after restart", 1, 1);

      // R3: timer disabled
      cfg_dur_sel_i = 2'd0; cfg_tmr_en_i = 1'b0;
      restart();
      tk(12); idle(); expect_now("R3 disabled no expiry", 0, 0);
      cfg_tmr_en_i = 1'b1;
      tk(3); idle(); expect_now("R3 re-enabled counts from held zero", 0, 0);
      tk(1); idle(); expect_now("R3 re-enabled expiry", 1, 1);

      // R4: half rate under each slowing flag
      cfg_dbl_en_i = 1'b1; iin_reg_i = 1'b1;
      restart();
      tk(7); idle(); expect_now("R4 iin half rate before", 0, 0);
      tk(1); idle(); expect_now("R4 iin half rate expiry", 1, 1);
      iin_reg_i = 1'b0; vin_reg_i = 1'b1;
      restart();
      tk(7); idle(); expect_now("R4 vin half rate before", 0, 0);
      tk(1); idle(); expect_now("R4 vin half rate expiry", 1, 1);
      vin_reg_i = 1'b0; temp_derate_i = 1'b1; cfg_dur_sel_i = 2'd2;
      restart();
      tk(15); idle(); expect_now("R4 temp half rate before", 0, 0);
      tk(1);  idle(); expect_now("R4 temp half rate expiry", 1, 1);
      temp_derate_i = 1'b0;

      // R5: double-time disabled keeps full rate
      cfg_dbl_en_i = 1'b0; iin_reg_i = 1'b1; cfg_dur_sel_i = 2'd0;
      restart();
      tk(3); idle(); expect_now("R5 full rate before", 0, 0);
      tk(1); idle(); expect_now("R5 full rate expiry", 1, 1);
      iin_reg_i = 1'b0;

      // R6: fault and inactive freeze
      restart();
      tk(2);
      chg_fault_i = 1'b1;
      tk(10);
      chg_fault_i = 1'b0;
      tk(1); idle(); expect_now("R6 fault froze count", 0, 0);
      tk(1); idle(); expect_now("R6 resumed to expiry", 1, 1);
      restart();
      tk(3);
      chg_active_i = 1'b0;
      tk(5); idle(); expect_now("R6 inactive frozen", 0, 0);
      chg_active_i = 1'b1;
      tk(1); idle(); expect_now("R6 inactive resumed expiry", 1, 1);

      // R8 / R9: pre-charge timer
      vbat_low_i = 1'b1; cfg_pre_en_i = 1'b1;
      restart();
      tk(2); idle(); expect_now("R8 pre before limit", 0, 0);
      tk(1); idle(); expect_now("R8 pre expiry", 1, 1);
      cfg_pre_en_i = 1'b0;
      restart();
      tk(10); idle(); expect_now("R9 pre disabled no expiry", 0, 0);
      vbat_low_i = 1'b0;
      tk(3); idle(); expect_now("R8 fast frozen while low", 0, 0);
      tk(1); idle(); expect_now("R8 fast expiry after low", 1, 1);

      // R1: longest select
      cfg_dur_sel_i = 2'd3;
      restart();
      tk(9); idle(); expect_now("R1 before limit sel3", 0, 0);
      tk(1); idle(); expect_now("R1 expiry sel3", 1, 1);

      idle(); idle();
      done = 1;
      finish_run();
   end
endmodule